// File: doc/BRIEF.md
# Camera Receiver Control and Status Registers

This block is the register file that sits beside a serial camera-link receiver datapath. Software reaches it through a small 32-bit register bus (select, write, address, write data, read data, ready). It keeps the receiver enable, pair polarity swap, PHY settle time and lane configuration. It also keeps the image data type, virtual channel and frame resolution, and it holds the event status and interrupt mask.

Lane count, output alignment, data type, virtual channel and resolution are written into working copies. The datapath does not see them until software sets the commit bit in the control register, which copies the working set into the active set in one step. Enable, polarity swap and settle time act at once. The PHY lane enables are not stored: they are derived from the active lane count and the enable bit.

Single-cycle event pulses from the datapath set sticky status bits. Software clears these bits by writing ones to them, and a single interrupt line reports any status bit that is also set in the mask. A soft-reset bit clears the status and the active set. It then clears itself after a fixed number of cycles, and the bus is stalled until it does.

Top module: `camrx_regs`

## Requirements
- R1: After reset, reads return control 0x00000000, PHY 0x00000000, configuration 0x00000078 (data type 0x1E), resolution 0x00010001, mask 0 and status 0. irq is low, bus_ready is high, and the active outputs carry lanes-minus-one 0, data type 0x1E, channel 0, and width and height 1.
- R2: The lane field (control bits 3:2, lanes minus one), the 32-bit alignment bit (control bit 20), and the configuration (data type in bits 7:2, channel in bits 1:0) go to working copies, as does the resolution (width 31:16, height 15:0). The rx_ outputs keep their old values until a control write with bit 16 set. That write copies the working set, including the fields written by that same write, to the outputs at the edge that accepts it. Bit 16 reads back as 0.
- R3: Control bit 0 (enable), control bit 31 (pair swap) and PHY bits 31:27 (settle) drive rx_enable, rx_pair_swap and phy_settle from the edge that accepts the write, without a commit.
- R4: phy_lane_en is 0 while the receiver is disabled. When enabled it is (1<<(N+1))-1, where N is the active lane count (active lanes-minus-one plus one). PHY register bits 4:0 read back the same value.
- R5: Event inputs set status bits one edge after the pulse, and the bits stay set. The layout is: bit 0 unknown ID, bit 1 CRC, bit 2 ECC, bit 3 overflow, bit 4 lost frame end, bit 5 lost frame start, bits 15:12 start-of-transmission errors, bit 26 frame end, bit 27 frame start, bit 28 data after odd frame, bit 29 before odd frame, bit 30 after even frame, bit 31 before even frame.
- R6: A write to the status register (0x14) clears exactly the bits written as 1. If an event arrives in the same cycle as the clear of its bit, the bit stays set.
- R7: irq is high exactly when some status bit is set together with the same bit of the mask register (0x10). The mask keeps only the implemented status positions (0xFC00F03F).
- R8: A data type write keeps the code only if it is 0x1E, 0x2A, 0x2B, 0x2C or 0x30 to 0x33. Any other code is stored as 0x1E.
- R9: A width or height of 0 written to the resolution register (0x2C) is stored as 1.
- R10: Writing control bit 4 drops bus_ready for exactly RST_CYC cycles, starting at the next cycle. It clears the status, restores the active set to its reset values and drops events that arrive meanwhile. Bit 4 then reads 0. Working copies and the mask keep their values.
- R11: Reads of unmapped addresses return 0, writes to them change nothing, and unimplemented status and mask bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while selected and ready |
| bus_ready | output | 1 | Low while a soft reset runs |
| ev_err_id | input | 1 | Unknown packet ID pulse |
| ev_err_crc | input | 1 | CRC error pulse |
| ev_err_ecc | input | 1 | Header ECC error pulse |
| ev_overflow | input | 1 | FIFO overflow pulse |
| ev_lost_fe | input | 1 | Lost frame end pulse |
| ev_lost_fs | input | 1 | Lost frame start pulse |
| ev_sot | input | 4 | Start-of-transmission error pulses per lane |
| ev_frame_end | input | 1 | Frame end pulse |
| ev_frame_start | input | 1 | Frame start pulse |
| ev_nid | input | 4 | Non-image data: after odd, before odd, after even, before even |
| irq | output | 1 | Masked interrupt |
| rx_enable | output | 1 | Receiver enable |
| rx_pair_swap | output | 1 | Differential polarity swap |
| rx_lanes_m1 | output | 2 | Active lanes minus one |
| rx_align32 | output | 1 | Active 32-bit alignment (0 = 24-bit) |
| rx_dtype | output | 6 | Active data type |
| rx_vc | output | 2 | Active virtual channel |
| rx_width | output | 16 | Active width |
| rx_height | output | 16 | Active height |
| phy_lane_en | output | 5 | Clock and data lane enables |
| phy_settle | output | 5 | Settle time |

## Verification
Every register, status bit and active output changes at the clock edge that accepts the write or takes the event pulse, so each result is due one edge after its stimulus. The bench drives at the falling edge and samples at the next falling edge, after that single register stage. Read data is combinational, so the bench samples it in the same half-cycle in which it drives the address. This read sees the status as it stood before an event driven in that same cycle. The soft-reset stall is measured by counting the falling edges at which bus_ready is low, which must equal the reset length exactly.

// File: rtl/camrx_pkg.sv
package camrx_pkg;
    localparam int unsigned DW    = 32;
    localparam int unsigned PIX_W = 16;
    localparam int unsigned DT_W  = 6;
    localparam int unsigned VC_W  = 2;
    localparam int unsigned LN_W  = 2;

    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_PHY  = 'h04;
    localparam int unsigned OFS_CFG  = 'h08;
    localparam int unsigned OFS_MASK = 'h10;
    localparam int unsigned OFS_SRC  = 'h14;
    localparam int unsigned OFS_RES  = 'h2C;

    localparam logic [DW-1:0] SRC_VALID = 32'hFC00_F03F;

    localparam logic [DT_W-1:0] DT_YUV8  = 6'h1E;
    localparam logic [DT_W-1:0] DT_RAW8  = 6'h2A;
    localparam logic [DT_W-1:0] DT_RAW10 = 6'h2B;
    localparam logic [DT_W-1:0] DT_RAW12 = 6'h2C;
    localparam logic [DT_W-1:0] DT_USER  = 6'h30;

    typedef struct packed {
        logic [LN_W-1:0]  lanes_m1;
        logic             align32;
        logic [DT_W-1:0]  dtype;
        logic [VC_W-1:0]  vc;
        logic [PIX_W-1:0] width;
        logic [PIX_W-1:0] height;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{lanes_m1: '0, align32: 1'b0, dtype: DT_YUV8,
                                   vc: '0, width: 16'd1, height: 16'd1};

    function automatic logic dtype_ok(input logic [DT_W-1:0] c);
        return (c == DT_YUV8) || (c == DT_RAW8) || (c == DT_RAW10) ||
               (c == DT_RAW12) || (c[DT_W-1:2] == DT_USER[DT_W-1:2]);
    endfunction
endpackage

// File: rtl/camrx_lane_map.sv
module camrx_lane_map #(
    parameter int unsigned MAXL = 4
) (
    input  logic                     enable,
    input  logic [$clog2(MAXL)-1:0]  lanes_m1,
    output logic [MAXL:0]            lane_en
);
    localparam int unsigned NEN = MAXL + 1;

    // Lane 0 is the clock lane; data lane k sits at position k.
    for (genvar i = 0; i < NEN; i++) begin : g_lane
        assign lane_en[i] = enable && (i <= (int'(lanes_m1) + 1));
    end

    always_comb begin
        AST_LANE_CONTIG: assert (((lane_en + 1'b1) & lane_en) == '0);   // R4
        AST_LANE_MIN: assert (!enable || (lane_en[1:0] == 2'b11));       // R4
    end
endmodule

// File: rtl/camrx_cfg.sv
module camrx_cfg import camrx_pkg::*; #(
    parameter int unsigned RST_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_phy,
    input  logic          wr_cfg,
    input  logic          wr_res,
    input  logic [DW-1:0] wdata,
    output cfg_t          work_o,
    output cfg_t          act_o,
    output logic          enable_o,
    output logic          swap_o,
    output logic [4:0]    settle_o,
    output logic          busy_o
);
    localparam int unsigned CW = $clog2(RST_CYC + 1);

    typedef struct packed {
        cfg_t          work;
        cfg_t          act;
        logic          enable;
        logic          swap;
        logic [4:0]    settle;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  s_d, s_q;
    logic busy, trig, commit;

    assign busy   = (s_q.cnt != '0);
    assign trig   = wr_ctrl && wdata[4];
    assign commit = wr_ctrl && wdata[16];

    always_comb begin
        s_d = s_q;
        if (busy) s_d.cnt = s_q.cnt - 1'b1;
        if (wr_ctrl) begin
            s_d.enable        = wdata[0];
            s_d.work.lanes_m1 = wdata[3:2];
            s_d.work.align32  = wdata[20];
            s_d.swap          = wdata[31];
        end
        if (wr_phy) s_d.settle = wdata[31:27];
        if (wr_cfg) begin
            s_d.work.vc    = wdata[VC_W-1:0];
            s_d.work.dtype = dtype_ok(wdata[7:2]) ? wdata[7:2] : DT_YUV8;
        end
        if (wr_res) begin
            s_d.work.width  = (wdata[31:16] == '0) ? 16'd1 : wdata[31:16];
            s_d.work.height = (wdata[15:0]  == '0) ? 16'd1 : wdata[15:0];
        end
        if (commit) s_d.act = s_d.work;
        if (trig)   s_d.cnt = CW'(RST_CYC);
        if (trig || busy) s_d.act = CFG_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{work: CFG_RESET, act: CFG_RESET, enable: 1'b0, swap: 1'b0,
                     settle: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign work_o   = s_q.work;
    assign act_o    = s_q.act;
    assign enable_o = s_q.enable;
    assign swap_o   = s_q.swap;
    assign settle_o = s_q.settle;
    assign busy_o   = busy;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_ctrl && (wdata[16] || wdata[4])) && !busy) |=> $stable(act_o)); // R2
    AST_DTYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dtype_ok(work_o.dtype));                                              // R8
    AST_RES_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (work_o.width != '0) && (work_o.height != '0));                       // R9
    AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (busy_o && (act_o == CFG_RESET)));                           // R10
endmodule

// File: rtl/camrx_status.sv
module camrx_status import camrx_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev,
    input  logic [DW-1:0] clr_vec,
    input  logic          clr_all,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] mask_o,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] mask;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.src  = (s_q.src & ~clr_vec) | (ev & SRC_VALID);
        if (clr_all) s_d.src = '0;
        if (wr_mask) s_d.mask = wdata & SRC_VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign src_o  = s_q.src;
    assign mask_o = s_q.mask;
    assign irq    = |(s_q.src & s_q.mask);

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((src_o & $past(ev & SRC_VALID)) == $past(ev & SRC_VALID))); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((src_o & ~$past(src_o) & ~$past(ev)) == '0));              // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((~src_o & $past(src_o) & ~$past(clr_vec)) == '0));         // R6
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (src_o == '0));                                              // R10
endmodule

// File: rtl/camrx_regs.sv
module camrx_regs import camrx_pkg::*; #(
    parameter int unsigned AW      = 8,
    parameter int unsigned RST_CYC = 4,
    parameter int unsigned MAXL    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_ready,
    input  logic             ev_err_id,
    input  logic             ev_err_crc,
    input  logic             ev_err_ecc,
    input  logic             ev_overflow,
    input  logic             ev_lost_fe,
    input  logic             ev_lost_fs,
    input  logic [3:0]       ev_sot,
    input  logic             ev_frame_end,
    input  logic             ev_frame_start,
    input  logic [3:0]       ev_nid,
    output logic             irq,
    output logic             rx_enable,
    output logic             rx_pair_swap,
    output logic [1:0]       rx_lanes_m1,
    output logic             rx_align32,
    output logic [5:0]       rx_dtype,
    output logic [1:0]       rx_vc,
    output logic [15:0]      rx_width,
    output logic [15:0]      rx_height,
    output logic [MAXL:0]    phy_lane_en,
    output logic [4:0]       phy_settle
);
    logic          acc, wr;
    logic          wr_ctrl, wr_phy, wr_cfg, wr_res, wr_mask, wr_src;
    logic          busy, clr_all;
    logic [DW-1:0] ev, clr_vec, src, mask;
    cfg_t          work, act;

    assign acc     = bus_sel && !busy;
    assign wr      = acc && bus_wr;
    assign wr_ctrl = wr && (bus_addr == AW'(OFS_CTRL));
    assign wr_phy  = wr && (bus_addr == AW'(OFS_PHY));
    assign wr_cfg  = wr && (bus_addr == AW'(OFS_CFG));
    assign wr_res  = wr && (bus_addr == AW'(OFS_RES));
    assign wr_mask = wr && (bus_addr == AW'(OFS_MASK));
    assign wr_src  = wr && (bus_addr == AW'(OFS_SRC));
    assign clr_vec = wr_src ? bus_wdata : '0;
    assign clr_all = busy || (wr_ctrl && bus_wdata[4]);
    assign bus_ready = !busy;

    always_comb begin
        ev         = '0;
        ev[0]      = ev_err_id;
        ev[1]      = ev_err_crc;
        ev[2]      = ev_err_ecc;
        ev[3]      = ev_overflow;
        ev[4]      = ev_lost_fe;
        ev[5]      = ev_lost_fs;
        ev[15:12]  = ev_sot;
        ev[26]     = ev_frame_end;
        ev[27]     = ev_frame_start;
        ev[31:28]  = ev_nid;
    end

    camrx_cfg #(.RST_CYC(RST_CYC)) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ctrl), .wr_phy(wr_phy), .wr_cfg(wr_cfg), .wr_res(wr_res),
        .wdata(bus_wdata), .work_o(work), .act_o(act),
        .enable_o(rx_enable), .swap_o(rx_pair_swap), .settle_o(phy_settle),
        .busy_o(busy)
    );

    camrx_status i_status (
        .clk(clk), .rst_n(rst_n), .ev(ev), .clr_vec(clr_vec), .clr_all(clr_all),
        .wr_mask(wr_mask), .wdata(bus_wdata), .src_o(src), .mask_o(mask), .irq(irq)
    );

    camrx_lane_map #(.MAXL(MAXL)) i_lanes (
        .enable(rx_enable), .lanes_m1(act.lanes_m1), .lane_en(phy_lane_en)
    );

    assign rx_lanes_m1 = act.lanes_m1;
    assign rx_align32  = act.align32;
    assign rx_dtype    = act.dtype;
    assign rx_vc       = act.vc;
    assign rx_width    = act.width;
    assign rx_height   = act.height;

    always_comb begin
        bus_rdata = '0;
        if (acc && !bus_wr) begin
            if (bus_addr == AW'(OFS_CTRL)) begin
                bus_rdata[0]   = rx_enable;
                bus_rdata[3:2] = work.lanes_m1;
                bus_rdata[4]   = busy;
                bus_rdata[20]  = work.align32;
                bus_rdata[31]  = rx_pair_swap;
            end else if (bus_addr == AW'(OFS_PHY)) begin
                bus_rdata[31:27] = phy_settle;
                bus_rdata[MAXL:0] = phy_lane_en;
            end else if (bus_addr == AW'(OFS_CFG)) begin
                bus_rdata[7:2] = work.dtype;
                bus_rdata[1:0] = work.vc;
            end else if (bus_addr == AW'(OFS_MASK)) begin
                bus_rdata = mask;
            end else if (bus_addr == AW'(OFS_SRC)) begin
                bus_rdata = src;
            end else if (bus_addr == AW'(OFS_RES)) begin
                bus_rdata = {work.width, work.height};
            end
        end
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));                                       // R11
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && bus_sel && bus_wr && (bus_addr == AW'(OFS_CFG))) |=> $stable(work.dtype)); // R10
endmodule

// File: tb/test_camrx_regs.sv
module test_camrx_regs;
    localparam logic [7:0] A_CTRL = 8'h00, A_PHY = 8'h04, A_CFG = 8'h08,
                           A_MASK = 8'h10, A_SRC = 8'h14, A_RES = 8'h2C;
    localparam logic [31:0] VALID = 32'hFC00_F03F;
    localparam int RST_LEN = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_ready;
    logic ev_err_id = 0, ev_err_crc = 0, ev_err_ecc = 0, ev_overflow = 0;
    logic ev_lost_fe = 0, ev_lost_fs = 0, ev_frame_end = 0, ev_frame_start = 0;
    logic [3:0] ev_sot = '0, ev_nid = '0;
    logic irq, rx_enable, rx_pair_swap, rx_align32;
    logic [1:0] rx_lanes_m1, rx_vc;
    logic [5:0] rx_dtype;
    logic [15:0] rx_width, rx_height;
    logic [4:0] phy_lane_en, phy_settle;

    int n_chk = 0, n_err = 0;

    camrx_regs i_camrx_regs (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ev(input logic [31:0] v);
        ev_err_id = v[0]; ev_err_crc = v[1]; ev_err_ecc = v[2]; ev_overflow = v[3];
        ev_lost_fe = v[4]; ev_lost_fs = v[5]; ev_sot = v[15:12];
        ev_frame_end = v[26]; ev_frame_start = v[27]; ev_nid = v[31:28];
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
        @(negedge clk); #1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic pulse_ev(input logic [31:0] v);
        @(negedge clk); set_ev(v);
        @(posedge clk); #1; set_ev('0);
        @(negedge clk); #1;
    endtask

    function automatic logic [4:0] lane_exp(input logic en, input int lanes_m1);
        return en ? 5'((1 << (lanes_m1 + 2)) - 1) : 5'd0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] m_src, m_mask;
        int lowc;
        r = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 ready", {31'd0, bus_ready}, 32'd1);
        chk("R1 rx_dtype", {26'd0, rx_dtype}, 32'h1E);
        chk("R1 rx_res", {rx_width, rx_height}, 32'h0001_0001);
        chk("R1 rx_lanes", {30'd0, rx_lanes_m1}, 32'd0);
        chk("R1 lanes_en", {27'd0, phy_lane_en}, 32'd0);
        bus_read(A_CTRL, r); chk("R1 ctrl", r, 32'h0);
        bus_read(A_PHY, r);  chk("R1 phy", r, 32'h0);
        bus_read(A_CFG, r);  chk("R1 cfg", r, 32'h78);
        bus_read(A_RES, r);  chk("R1 res", r, 32'h0001_0001);
        bus_read(A_MASK, r); chk("R1 mask", r, 32'h0);
        bus_read(A_SRC, r);  chk("R1 src", r, 32'h0);

        // R3 immediate fields
        bus_write(A_CTRL, 32'h8000_0001);
        chk("R3 enable", {31'd0, rx_enable}, 32'd1);
        chk("R3 swap", {31'd0, rx_pair_swap}, 32'd1);
        chk("R4 one lane", {27'd0, phy_lane_en}, {27'd0, lane_exp(1'b1, 0)});
        bus_write(A_PHY, 32'hF800_0000);
        chk("R3 settle", {27'd0, phy_settle}, 32'h1F);
        bus_read(A_PHY, r); chk("R4 phy readback", r, 32'hF800_0003);

        // R2 working copies held until commit
        bus_write(A_CFG, 32'h0000_00AD);
        bus_write(A_RES, 32'h0280_01E0);
        bus_write(A_CTRL, 32'h8010_0009);
        chk("R2 dtype held", {26'd0, rx_dtype}, 32'h1E);
        chk("R2 res held", {rx_width, rx_height}, 32'h0001_0001);
        chk("R2 lanes held", {30'd0, rx_lanes_m1}, 32'd0);
        chk("R2 align held", {31'd0, rx_align32}, 32'd0);
        chk("R4 lanes before commit", {27'd0, phy_lane_en}, 32'h3);
        bus_read(A_CFG, r); chk("R2 cfg working", r, 32'hAD);
        bus_write(A_CTRL, 32'h8011_0009);
        chk("R2 dtype commit", {26'd0, rx_dtype}, 32'h2B);
        chk("R2 vc commit", {30'd0, rx_vc}, 32'd1);
        chk("R2 res commit", {rx_width, rx_height}, 32'h0280_01E0);
        chk("R2 lanes commit", {30'd0, rx_lanes_m1}, 32'd2);
        chk("R2 align commit", {31'd0, rx_align32}, 32'd1);
        chk("R4 three lanes", {27'd0, phy_lane_en}, {27'd0, lane_exp(1'b1, 2)});
        bus_read(A_CTRL, r); chk("R2 ctrl readback", r, 32'h8010_0009);
        bus_write(A_CTRL, 32'h0001_000D);
        chk("R4 four lanes", {27'd0, phy_lane_en}, 32'h1F);
        bus_write(A_CTRL, 32'h0000_000C);
        chk("R4 disabled", {27'd0, phy_lane_en}, 32'h0);

        // R8 data type filter
        bus_write(A_CFG, 32'h0000_0094); bus_read(A_CFG, r); chk("R8 bad 0x25", r, 32'h78);
        bus_write(A_CFG, 32'h0000_00BC); bus_read(A_CFG, r); chk("R8 bad 0x2F", r, 32'h78);
        bus_write(A_CFG, 32'h0000_00A8); bus_read(A_CFG, r); chk("R8 raw8", r, 32'hA8);
        bus_write(A_CFG, 32'h0000_00CF); bus_read(A_CFG, r); chk("R8 user3", r, 32'hCF);

        // R9 zero resolution
        bus_write(A_RES, 32'h0000_0000); bus_read(A_RES, r); chk("R9 zero", r, 32'h0001_0001);
        bus_write(A_RES, 32'hFFFF_0000); bus_read(A_RES, r); chk("R9 height zero", r, 32'hFFFF_0001);

        // R11 unmapped and reserved bits
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, r); chk("R11 unmapped read", r, 32'h0);
        bus_read(A_CFG, r); chk("R11 unmapped write", r, 32'hCF);
        bus_write(A_MASK, 32'hFFFF_FFFF);
        bus_read(A_MASK, r); chk("R11 mask reserved", r, VALID);
        bus_write(A_MASK, 32'h0);

        // R5 per-event layout, mask zero keeps irq low (R7)
        for (int b = 0; b < 32; b++) begin
            pulse_ev(32'h1 << b);
            bus_read(A_SRC, r);
            chk($sformatf("R5 bit %0d", b), r, (32'h1 << b) & VALID);
            chk("R7 masked", {31'd0, irq}, 32'd0);
            bus_write(A_SRC, 32'hFFFF_FFFF);
        end

        // R6 partial clear and event/clear collision
        pulse_ev(32'h0800_0001);
        bus_write(A_SRC, 32'h0000_0001);
        bus_read(A_SRC, r); chk("R6 partial clear", r, 32'h0800_0000);
        @(negedge clk);
        set_ev(32'h1000_0000);
        bus_sel = 1; bus_wr = 1; bus_addr = A_SRC; bus_wdata = 32'h1800_0000;
        @(posedge clk); #1; set_ev('0); bus_sel = 0; bus_wr = 0;
        bus_read(A_SRC, r); chk("R6 event wins", r, 32'h1000_0000);
        bus_write(A_SRC, 32'hFFFF_FFFF);

        // R7 directed irq
        bus_write(A_MASK, 32'h0800_0000);
        pulse_ev(32'h0400_0000);
        chk("R7 unmasked bit", {31'd0, irq}, 32'd0);
        pulse_ev(32'h0800_0000);
        chk("R7 masked bit", {31'd0, irq}, 32'd1);
        bus_write(A_SRC, 32'hFFFF_FFFF);
        chk("R7 after clear", {31'd0, irq}, 32'd0);

        // Random events, clears and reads against a model (R5 R6 R7)
        m_src = 32'h0;
        r = $urandom;
        bus_write(A_MASK, r);
        m_mask = r & VALID;
        for (int it = 0; it < 400; it++) begin
            logic [31:0] ev, cv;
            int op;
            ev = $urandom & $urandom & $urandom;
            cv = $urandom;
            op = int'($urandom % 3);
            @(negedge clk);
            chk("R7 random irq", {31'd0, irq}, {31'd0, |(m_src & m_mask)});
            set_ev(ev);
            bus_sel = 1; bus_addr = A_SRC; bus_wr = (op == 0); bus_wdata = cv;
            #1;
            if (op == 1) chk("R5 random src", bus_rdata, m_src);
            @(posedge clk); #1;
            set_ev('0); bus_sel = 0; bus_wr = 0;
            if (op == 0) m_src = (m_src & ~cv) | (ev & VALID);
            else         m_src = m_src | (ev & VALID);
        end

        // R10 soft reset
        bus_write(A_CTRL, 32'h0001_0001);
        chk("R2 user dtype active", {26'd0, rx_dtype}, 32'h33);
        bus_write(A_MASK, VALID);
        pulse_ev(32'h0C00_0001);
        chk("R10 irq before", {31'd0, irq}, 32'd1);
        bus_write(A_CTRL, 32'h0000_0011);
        lowc = 0;
        if (!bus_ready) lowc++;
        set_ev(32'h0800_0001);
        @(posedge clk); #1; set_ev('0);
        @(negedge clk); #1;
        while (!bus_ready) begin lowc++; @(negedge clk); #1; end
        chk("R10 stall cycles", lowc, RST_LEN);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        chk("R10 dtype default", {26'd0, rx_dtype}, 32'h1E);
        chk("R10 vc default", {30'd0, rx_vc}, 32'd0);
        chk("R10 res default", {rx_width, rx_height}, 32'h0001_0001);
        bus_read(A_SRC, r);  chk("R10 src cleared", r, 32'h0);
        bus_read(A_CTRL, r); chk("R10 self clear", r, 32'h0000_0001);
        bus_read(A_CFG, r);  chk("R10 working kept", r, 32'hCF);
        bus_read(A_MASK, r); chk("R10 mask kept", r, VALID);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule